// File: doc/BRIEF.md
# Serial Receive FIFO with Programmable Occupancy Thresholds

This block is the receive-side byte store of a serial port, paired with its control word. The receiver pushes bytes in and the CPU pops them out in arrival order. Two occupancy thresholds are selected independently through encoded fields of the control word. The first sets a sticky data-ready flag for software. The second drives a registered request-to-send output for hardware flow control.

The same control word holds three more things. One bit holds the receive FIFO empty. Another bit is a clear request for the transmit FIFO, which lives elsewhere. The word also carries a loopback enable and a modem-control enable, and this block passes both out to neighbouring logic.

A push into a full FIFO is discarded and leaves a sticky overrun indication. Popping an empty FIFO is harmless. The block has no serial shifter and no transmit logic.

Top module: `serial_rx_fifo`

## Requirements
- R1: The control word is 16 bits wide and resets to zero. Bits 10..0 are written by `reg_wr` and read back on `reg_rdata`. Bits 15..11 always read as zero, whatever was written to them.
- R2: Control bits 10..8 select the RTS level: 0→127, 1→1, 2→16, 3→32, 4→64, 5→96, 6→108, 7→120. `rts_out` is a register. On each clock it loads 1 when the current occupancy is strictly greater than the selected level, and 0 otherwise.
- R3: Control bits 7..6 select the data-ready level: 0→1, 1→16, 2→64, 3→96. On any clock where the occupancy is at or above the selected level, `data_ready` becomes 1 in the next cycle.
- R4: `data_ready` holds its value until a `rdy_clr` pulse arrives. That pulse clears it in the next cycle only if the occupancy is then below the selected level. Otherwise the flag stays 1.
- R5: The FIFO holds up to 128 bytes. Bytes pop out in push order. `rx_count` gives the current occupancy and never exceeds 128.
- R6: A push while the FIFO is full is dropped and sets `rx_overrun`, which stays set. A push and a pop in the same cycle on a full FIFO are both accepted.
- R7: While the FIFO is empty, `pop_data` reads 0. A pop request on an empty FIFO leaves `rx_count` at 0.
- R8: While control bit 1 is 1, the receive FIFO is held empty: the count is zero, pushes and pops are ignored, and the overrun indication is cleared. Normal operation resumes after software writes the bit back to 0.
- R9: Control bit 0 drives `loop_en`, bit 2 drives `tx_fifo_clr` and bit 3 drives `modem_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write value |
| reg_rdata | output | 16 | Control word read value |
| rdy_clr | input | 1 | Software request to clear the data-ready flag |
| push_valid | input | 1 | Receiver pushes a byte |
| push_data | input | 8 | Byte pushed by the receiver |
| pop_req | input | 1 | CPU pops the oldest byte |
| pop_data | output | 8 | Oldest stored byte, 0 when empty |
| rx_count | output | 8 | Receive FIFO occupancy |
| data_ready | output | 1 | Sticky data-ready flag |
| rts_out | output | 1 | Registered flow-control request |
| rx_overrun | output | 1 | Sticky overrun indication |
| loop_en | output | 1 | Loopback enable |
| modem_en | output | 1 | Modem-control enable |
| tx_fifo_clr | output | 1 | Transmit FIFO clear request |

## Verification
The bench targets the edge between the two comparison rules. With both levels at 16 and exactly 16 bytes stored, the flag must be set while RTS stays low. A design that used the same rule for both would raise RTS one byte early, or set the flag one byte late.

The bench clears the flag while the occupancy is still high and expects it to stay set. An unconditional clear would drop it here. It also pushes beyond 128 bytes, and pushes and pops together while full, to catch an overflowing count or a lost byte.

Finally, the bench holds the receive clear bit while pushing, pops an empty FIFO, and writes all ones to the control word. A wrong design would show data leaking in under the clear bit, a count that wraps below zero, or reserved bits that read back as ones.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int CTRL_W    = 16;
   localparam int CTRL_USED = 11;
   localparam int B_LOOP    = 0;
   localparam int B_RXCLR   = 1;
   localparam int B_TXCLR   = 2;
   localparam int B_MODEM   = 3;
   localparam int B_RDY_LO  = 6;
   localparam int B_RTS_LO  = 8;
   localparam int MIN_DEPTH = 128;

   function automatic int rts_level(input logic [2:0] sel);
      case (sel)
         3'd0:    return 127;
         3'd1:    return 1;
         3'd2:    return 16;
         3'd3:    return 32;
         3'd4:    return 64;
         3'd5:    return 96;
         3'd6:    return 108;
         default: return 120;
      endcase
   endfunction

   function automatic int rdy_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 16;
         2'd2:    return 64;
         default: return 96;
      endcase
   endfunction
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
   import rxf_pkg::*;
#(
   parameter int REG_W  = CTRL_W,
   parameter int USED_W = CTRL_USED
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic [2:0]       rts_sel,
   output logic [1:0]       rdy_sel,
   output logic             rx_clr,
   output logic             tx_clr,
   output logic             loop_en,
   output logic             modem_en
);
   generate
      if (USED_W > REG_W || USED_W < B_RTS_LO + 3) begin : g_bad_width
         $error("rxf_ctrl: control field layout does not fit REG_W");
      end
   endgenerate

   logic [USED_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl_q <= '0;
      else if (wr) ctrl_q <= wdata[USED_W-1:0];
   end

   assign rdata    = REG_W'(ctrl_q);
   assign rts_sel  = ctrl_q[B_RTS_LO +: 3];
   assign rdy_sel  = ctrl_q[B_RDY_LO +: 2];
   assign rx_clr   = ctrl_q[B_RXCLR];
   assign tx_clr   = ctrl_q[B_TXCLR];
   assign loop_en  = ctrl_q[B_LOOP];
   assign modem_en = ctrl_q[B_MODEM];
endmodule

// File: rtl/rxf_storage.sv
module rxf_storage #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 128,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  count,
   output logic              overrun
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   generate
      if (DEPTH < 2 || CNT_W < $clog2(DEPTH + 1)) begin : g_bad_depth
         $error("rxf_storage: DEPTH or CNT_W out of range");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_next, rd_next;
   logic              full, empty, do_pop, do_push;

   assign full    = count == CNT_W'(DEPTH);
   assign empty   = count == '0;
   assign do_pop  = pop && !empty && !clr;
   assign do_push = push && !clr && (!full || do_pop);

   generate
      if (POW2) begin : g_pow2_wrap
         assign wr_next = wr_ptr + PTR_W'(1);
         assign rd_next = rd_ptr + PTR_W'(1);
      end else begin : g_cmp_wrap
         assign wr_next = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_next = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else if (clr) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_next;
         if (do_pop)  rd_ptr <= rd_next;
         case ({do_push, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
         if (push && !do_push) overrun <= 1'b1;
      end
   end

   assign pop_data = empty ? '0 : mem[rd_ptr];

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (overrun && count == CNT_W'(DEPTH)));

   assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> count == '0);

   assert_clr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0 && !overrun));
endmodule

// File: rtl/rxf_thresh.sv
module rxf_thresh
   import rxf_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [2:0]       rts_sel,
   input  logic [1:0]       rdy_sel,
   input  logic             rdy_clr,
   output logic             data_ready,
   output logic             rts_out
);
   generate
      if (CNT_W < 8) begin : g_bad_cnt
         $error("rxf_thresh: CNT_W too narrow for the threshold levels");
      end
   endgenerate

   logic [CNT_W-1:0] rts_lvl, rdy_lvl;
   logic             rdy_hit;

   assign rts_lvl = CNT_W'(rts_level(rts_sel));
   assign rdy_lvl = CNT_W'(rdy_level(rdy_sel));
   assign rdy_hit = count >= rdy_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_out    <= 1'b0;
         data_ready <= 1'b0;
      end else begin
         rts_out <= count > rts_lvl;
         if (rdy_hit)      data_ready <= 1'b1;
         else if (rdy_clr) data_ready <= 1'b0;
      end
   end

   assert_rts_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |=> !rts_out);

   assert_rdy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_hit |=> data_ready);

   assert_rdy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ready && !rdy_clr) |=> data_ready);
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
   import rxf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 128,
   parameter int REG_W  = CTRL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              rdy_clr,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_req,
   output logic [DATA_W-1:0] pop_data,
   output logic [$clog2(DEPTH+1)-1:0] rx_count,
   output logic              data_ready,
   output logic              rts_out,
   output logic              rx_overrun,
   output logic              loop_en,
   output logic              modem_en,
   output logic              tx_fifo_clr
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < MIN_DEPTH) begin : g_bad_depth
         $error("serial_rx_fifo: DEPTH must reach the highest threshold");
      end
   endgenerate

   logic [2:0] rts_sel;
   logic [1:0] rdy_sel;
   logic       rx_clr;

   rxf_ctrl #(.REG_W(REG_W), .USED_W(CTRL_USED)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .rdata(reg_rdata),
      .rts_sel(rts_sel), .rdy_sel(rdy_sel), .rx_clr(rx_clr), .tx_clr(tx_fifo_clr),
      .loop_en(loop_en), .modem_en(modem_en)
   );

   rxf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_store (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(push_valid), .push_data(push_data),
      .pop(pop_req), .pop_data(pop_data), .count(rx_count), .overrun(rx_overrun)
   );

   rxf_thresh #(.CNT_W(CNT_W)) i_thresh (
      .clk(clk), .rst_n(rst_n), .count(rx_count), .rts_sel(rts_sel), .rdy_sel(rdy_sel),
      .rdy_clr(rdy_clr), .data_ready(data_ready), .rts_out(rts_out)
   );
endmodule

// File: tb/test_serial_rx_fifo.sv
module test_serial_rx_fifo;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        reg_wr = 0;
   logic [15:0] reg_wdata = 0;
   logic [15:0] reg_rdata;
   logic        rdy_clr = 0;
   logic        push_valid = 0;
   logic [7:0]  push_data = 0;
   logic        pop_req = 0;
   logic [7:0]  pop_data;
   logic [7:0]  rx_count;
   logic        data_ready, rts_out, rx_overrun, loop_en, modem_en, tx_fifo_clr;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   serial_rx_fifo i_serial_rx_fifo (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rdy_clr(rdy_clr), .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
      .pop_data(pop_data), .rx_count(rx_count), .data_ready(data_ready), .rts_out(rts_out),
      .rx_overrun(rx_overrun), .loop_en(loop_en), .modem_en(modem_en), .tx_fifo_clr(tx_fifo_clr)
   );

   always #5 clk = ~clk;

   // reference model
   int       rts_tab [8] = '{127, 1, 16, 32, 64, 96, 108, 120};
   int       rdy_tab [4] = '{1, 16, 64, 96};
   byte unsigned q[$];
   int       m_ctrl = 0;
   bit       m_rdy = 0, m_rts = 0, m_ovr = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); m_ctrl = 0; m_rdy = 0; m_rts = 0; m_ovr = 0;
      end else begin
         int  cnt;
         bit  popping, accept;
         cnt   = q.size();
         m_rts = cnt > rts_tab[(m_ctrl >> 8) & 7];
         if (cnt >= rdy_tab[(m_ctrl >> 6) & 3]) m_rdy = 1;
         else if (rdy_clr) m_rdy = 0;
         if ((m_ctrl >> 1) & 1) begin
            q.delete(); m_ovr = 0;
         end else begin
            popping = pop_req && cnt > 0;
            accept  = push_valid && (cnt < 128 || popping);
            if (push_valid && !accept) m_ovr = 1;
            if (popping) void'(q.pop_front());
            if (accept) q.push_back(push_data);
         end
         if (reg_wr) m_ctrl = reg_wdata & 16'h07FF;
      end
   end

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check("R1", "reg_rdata", reg_rdata, m_ctrl);
      check("R2", "rts_out", rts_out, m_rts);
      check("R3", "data_ready", data_ready, m_rdy);
      check("R5", "rx_count", rx_count, q.size());
      check("R6", "rx_overrun", rx_overrun, m_ovr);
      check("R7", "pop_data", pop_data, (q.size() > 0) ? q[0] : 0);
      check("R9", "loop_en", loop_en, m_ctrl & 1);
      check("R9", "tx_fifo_clr", tx_fifo_clr, (m_ctrl >> 2) & 1);
      check("R9", "modem_en", modem_en, (m_ctrl >> 3) & 1);
   endtask

   task automatic step();
      @(negedge clk);
      compare_all();
      reg_wr = 0; rdy_clr = 0; push_valid = 0; pop_req = 0;
   endtask

   task automatic wr_ctrl(input logic [15:0] v);
      reg_wr = 1; reg_wdata = v; step();
   endtask

   task automatic push_n(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         push_valid = 1; push_data = 8'((seed + i * 7) & 8'hFF); step();
      end
   endtask

   task automatic pop_n(input int n);
      for (int i = 0; i < n; i++) begin
         pop_req = 1; step();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // reset state
      check("R1", "reset reg_rdata", reg_rdata, 0);
      check("R5", "reset rx_count", rx_count, 0);
      check("R2", "reset rts_out", rts_out, 0);
      check("R3", "reset data_ready", data_ready, 0);

      // R1: reserved bits read zero
      wr_ctrl(16'hFFFF);
      check("R1", "reserved bits", reg_rdata, 16'h07FF);
      wr_ctrl(16'h0000);
      // R9: side bits
      wr_ctrl(16'h000D);
      check("R9", "loop/tx/modem", {29'd0, modem_en, tx_fifo_clr, loop_en}, 7);

      // both levels 16: flag at 16, RTS only above 16
      wr_ctrl(16'h0240);
      push_n(16, 3);
      step();
      check("R3", "flag at level 16", data_ready, 1);
      check("R2", "rts at exactly 16", rts_out, 0);
      push_n(4, 50);
      step();
      check("R2", "rts above 16", rts_out, 1);
      // R4: clear while above level keeps the flag
      rdy_clr = 1; step();
      check("R4", "clear ignored above level", data_ready, 1);
      pop_n(10);
      rdy_clr = 1; step();
      check("R4", "clear below level", data_ready, 0);

      // R7: pop empty
      pop_n(10);
      #1 check("R7", "empty pop_data", pop_data, 0);
      pop_req = 1; step();
      check("R7", "count after empty pop", rx_count, 0);

      // R6: fill beyond full, level 127
      wr_ctrl(16'h00C0);
      push_n(130, 9);
      step();
      check("R6", "overrun set", rx_overrun, 1);
      check("R5", "count capped", rx_count, 128);
      check("R2", "rts 128 > 127", rts_out, 1);
      push_valid = 1; push_data = 8'hA5; pop_req = 1; step();
      check("R6", "push+pop on full", rx_count, 128);

      // R8: receive clear holds empty
      wr_ctrl(16'h0002);
      step();
      check("R8", "count under clear", rx_count, 0);
      check("R8", "overrun cleared", rx_overrun, 0);
      push_n(5, 1);
      check("R8", "push ignored under clear", rx_count, 0);
      wr_ctrl(16'h0000);
      push_n(1, 77);
      check("R8", "resume after clear", rx_count, 1);
      #1 check("R8", "byte after clear", pop_data, 77);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         push_valid = ($urandom_range(0, 99) < 55);
         push_data  = 8'($urandom);
         pop_req    = ($urandom_range(0, 99) < 45);
         rdy_clr    = ($urandom_range(0, 99) < 5);
         if ($urandom_range(0, 99) < 2) begin
            reg_wr    = 1;
            reg_wdata = 16'($urandom) & ((($urandom_range(0, 7)) == 0) ? 16'hFFFF : 16'hFFFD);
         end
         step();
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule